// File: doc/BRIEF.md
# Floating-Point Range Exception Resolver

This block sits after a floating-point rounder and settles the results that fall outside the normal exponent range. Each cycle it can accept one result: the sign, the rounded exponent (signed, extended range, biased for the target precision), the rounded fraction, the rounder's inexact and rounded-up indications, a tiny flag judged before rounding, and a denormalized-and-rounded alternative computed by an external denormalizer. Using the rounding mode, the precision flag and the overflow and underflow trap enables, it picks the word to write to the 64-bit destination register. It also produces the fraction-inexact (FI) and fraction-rounded (FR) bits and a 5-bit result class, and it accumulates sticky overflow, underflow and inexact status flags.

Single-precision results are written in the register's 64-bit double layout, with the exponent rebiased by +896. When a trap is enabled, an out-of-range exponent is wrapped by a precision-specific constant so that a handler receives a normal number. When the trap is disabled, overflow saturates to infinity or to the largest finite value, depending on the rounding mode and the sign, and underflow delivers the denormalized word.

Top module: `fp_range_resolver`

## Requirements
- R1: The output is registered. `out_valid` rises in the cycle after `in_valid` is accepted, and `out_word`, `out_class`, `out_fi` and `out_fr` belong to that input.
- R2: Overflow means `in_exp` is greater than 2046 (double) or 254 (single), with `in_zero` low. It sets `flag_ovf` whether or not `ovf_en` is set.
- R3: On overflow with `ovf_en` low, the word is chosen by `rmode` (0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf). Mode 0 gives signed infinity. Mode 1 gives the signed largest finite value. Mode 2 gives +inf for positive results and the negative largest finite value for negative results. Mode 3 gives -inf for negative results and the positive largest finite value for positive results.
- R4: On overflow with `ovf_en` low, `out_fi` is 1, `out_fr` is 0 and `flag_inx` is set. The class is infinity or normal, with the result's sign.
- R5: On overflow with `ovf_en` high, the stored exponent is `in_exp` minus 1536 (double) or minus 192 (single). The fraction is kept, the class is normal, and `out_fi`/`out_fr` copy `rnd_inexact`/`rnd_up`.
- R6: A tiny, nonzero result with `unf_en` high sets `flag_unf`. It stores `in_exp` plus 1536 (double) or plus 192 (single), and its class is normal.
- R7: A tiny result with `unf_en` low stores `den_word`. Its class is denormal, or zero when `den_zero` is set. `flag_unf` is set only if `den_inexact` is set, and `out_fi`/`out_fr` copy `den_inexact`/`den_up`.
- R8: `flag_inx` is set by `rnd_inexact` for in-range and trapped results, by `den_inexact` for untrapped tiny results, and always by untrapped overflow.
- R9: The status flags are sticky. Only `clr_flags` clears them, and an event accepted in the same cycle as the clear still sets its flag.
- R10: Single results use the double layout: exponent field = single exponent + 896, fraction in bits 51:29. Infinity has exponent field 2047, and the single largest finite value is exponent field 1150 with bits 51:29 all ones.
- R11: Class codes: +normal 00100, -normal 01000, +zero 00010, -zero 10010, +inf 00101, -inf 01001, +denormal 10100, -denormal 11000. An in-range nonzero result is normal, and `in_zero` gives a signed zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input result present |
| in_sign | input | 1 | Sign of the result |
| in_exp | input | EXP_W | Signed rounded exponent, biased for the target precision |
| in_frac | input | 52 | Rounded fraction (single: bits 51:29) |
| in_single | input | 1 | Single-precision operation |
| in_zero | input | 1 | Exact zero result |
| in_tiny | input | 1 | Intermediate result is tiny |
| rnd_inexact | input | 1 | Rounded result differs from the exact one |
| rnd_up | input | 1 | Rounder incremented the fraction |
| den_word | input | 64 | Denormalized and rounded word |
| den_inexact | input | 1 | Denormalized word lost accuracy |
| den_up | input | 1 | Denormalized word was incremented |
| den_zero | input | 1 | Denormalized word is zero |
| rmode | input | 2 | Rounding mode |
| ovf_en | input | 1 | Overflow trap enable |
| unf_en | input | 1 | Underflow trap enable |
| clr_flags | input | 1 | Clear sticky flags |
| out_valid | output | 1 | Output result present |
| out_word | output | 64 | Value for the destination register |
| out_class | output | 5 | Result class code |
| out_fi | output | 1 | Fraction inexact |
| out_fr | output | 1 | Fraction rounded up |
| flag_ovf | output | 1 | Sticky overflow |
| flag_unf | output | 1 | Sticky underflow |
| flag_inx | output | 1 | Sticky inexact |

## Verification
The hardest case to reach is untrapped underflow that is exact. Here the result is tiny but no underflow is signalled, so the flag must stay clear while the denormalized word is still delivered. The stimulus reaches it by clearing the flags first, then sending a tiny result with the loss-of-accuracy input low, and then reading the flag state at the output. The eight combinations of overflow mode and sign are all driven with the trap disabled, and the clear is driven in the same cycle as an overflow to show that the new event survives the clear.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

    localparam int WORD_W  = 64;
    localparam int FRAC_W  = 52;
    localparam int DEXP_W  = 11;
    localparam int SGL_F_W = 23;
    localparam int REBIAS  = 896;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_PINF = 2'd2,
        RM_MINF = 2'd3
    } rmode_e;

    typedef enum logic [2:0] {
        K_NORM,
        K_ZERO,
        K_OVF_TRAP,
        K_OVF_SAT,
        K_UNF_TRAP,
        K_UNF_DEN
    } kind_e;

    localparam logic [4:0] CL_PNORM = 5'b00100;
    localparam logic [4:0] CL_NNORM = 5'b01000;
    localparam logic [4:0] CL_PZERO = 5'b00010;
    localparam logic [4:0] CL_NZERO = 5'b10010;
    localparam logic [4:0] CL_PINF  = 5'b00101;
    localparam logic [4:0] CL_NINF  = 5'b01001;
    localparam logic [4:0] CL_PDEN  = 5'b10100;
    localparam logic [4:0] CL_NDEN  = 5'b11000;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [4:0]        cls;
        logic              fi;
        logic              fr;
        logic              set_ovf;
        logic              set_unf;
        logic              set_inx;
    } verdict_t;

    // Build a register word from a target-biased exponent.
    function automatic logic [WORD_W-1:0] pack_word(
        input logic              sgn,
        input logic              single,
        input logic signed [15:0] e,
        input logic [FRAC_W-1:0] frac
    );
        logic signed [15:0] d;
        d = single ? 16'(e + 16'sd896) : e;
        return {sgn, d[DEXP_W-1:0], frac};
    endfunction

    function automatic logic [WORD_W-1:0] inf_word(input logic sgn);
        return {sgn, {DEXP_W{1'b1}}, {FRAC_W{1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] big_word(input logic sgn, input logic single);
        logic [WORD_W-1:0] w;
        if (single)
            w = {sgn, 11'(254 + REBIAS), {SGL_F_W{1'b1}}, {(FRAC_W-SGL_F_W){1'b0}}};
        else
            w = {sgn, {(DEXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
        return w;
    endfunction

    // Saturating overflow goes to infinity for this mode and sign?
    function automatic logic goes_inf(input rmode_e rm, input logic sgn);
        case (rm)
            RM_NEAR: return 1'b1;
            RM_ZERO: return 1'b0;
            RM_PINF: return ~sgn;
            default: return sgn;
        endcase
    endfunction

    function automatic logic [4:0] norm_cls(input logic sgn);
        return sgn ? CL_NNORM : CL_PNORM;
    endfunction

endpackage

// File: rtl/fxr_detect.sv
module fxr_detect
    import fxr_pkg::*;
#(
    parameter int EXP_W    = 13,
    parameter int EMAX_DBL = 2046,
    parameter int EMAX_SGL = 254
) (
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic                    in_single,
    input  logic                    in_zero,
    input  logic                    in_tiny,
    input  logic                    ovf_en,
    input  logic                    unf_en,
    output kind_e                   kind
);
    localparam int EMAX_MAX = (EMAX_DBL > EMAX_SGL) ? EMAX_DBL : EMAX_SGL;

    int  e_i;
    int  limit;
    logic too_big;

    always_comb begin
        e_i     = int'(in_exp);
        limit   = in_single ? EMAX_SGL : EMAX_DBL;
        too_big = (e_i > limit) && (limit <= EMAX_MAX);
        if (in_zero)
            kind = K_ZERO;
        else if (too_big)
            kind = ovf_en ? K_OVF_TRAP : K_OVF_SAT;
        else if (in_tiny)
            kind = unf_en ? K_UNF_TRAP : K_UNF_DEN;
        else
            kind = K_NORM;
    end
endmodule

// File: rtl/fxr_select.sv
module fxr_select
    import fxr_pkg::*;
#(
    parameter int EXP_W   = 13,
    parameter int ADJ_DBL = 1536,
    parameter int ADJ_SGL = 192
) (
    input  kind_e                   kind,
    input  logic                    in_sign,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [FRAC_W-1:0]       in_frac,
    input  logic                    in_single,
    input  logic                    rnd_inexact,
    input  logic                    rnd_up,
    input  logic [WORD_W-1:0]       den_word,
    input  logic                    den_inexact,
    input  logic                    den_up,
    input  logic                    den_zero,
    input  logic [1:0]              rmode,
    output verdict_t                vd
);
    int   adj;
    logic signed [15:0] e_plain;
    logic signed [15:0] e_down;
    logic signed [15:0] e_up;
    logic to_inf;

    always_comb begin
        adj     = in_single ? ADJ_SGL : ADJ_DBL;
        e_plain = 16'(int'(in_exp));
        e_down  = 16'(int'(in_exp) - adj);
        e_up    = 16'(int'(in_exp) + adj);
        to_inf  = goes_inf(rmode_e'(rmode), in_sign);

        vd         = '0;
        vd.fi      = rnd_inexact;
        vd.fr      = rnd_up;
        vd.set_inx = rnd_inexact;
        vd.cls     = norm_cls(in_sign);
        vd.word    = pack_word(in_sign, in_single, e_plain, in_frac);

        case (kind)
            K_ZERO: begin
                vd.word = {in_sign, {(WORD_W-1){1'b0}}};
                vd.cls  = in_sign ? CL_NZERO : CL_PZERO;
            end
            K_OVF_TRAP: begin
                vd.set_ovf = 1'b1;
                vd.word    = pack_word(in_sign, in_single, e_down, in_frac);
            end
            K_OVF_SAT: begin
                vd.set_ovf = 1'b1;
                vd.set_inx = 1'b1;
                vd.fi      = 1'b1;
                vd.fr      = 1'b0;
                if (to_inf) begin
                    vd.word = inf_word(in_sign);
                    vd.cls  = in_sign ? CL_NINF : CL_PINF;
                end else begin
                    vd.word = big_word(in_sign, in_single);
                end
            end
            K_UNF_TRAP: begin
                vd.set_unf = 1'b1;
                vd.word    = pack_word(in_sign, in_single, e_up, in_frac);
            end
            K_UNF_DEN: begin
                vd.set_unf = den_inexact;
                vd.set_inx = den_inexact;
                vd.fi      = den_inexact;
                vd.fr      = den_up;
                vd.word    = den_word;
                if (den_zero)
                    vd.cls = in_sign ? CL_NZERO : CL_PZERO;
                else
                    vd.cls = in_sign ? CL_NDEN : CL_PDEN;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fxr_status.sv
module fxr_status
    import fxr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              clr_flags,
    input  verdict_t          vd,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic [4:0]        out_class,
    output logic              out_fi,
    output logic              out_fr,
    output logic              flag_ovf,
    output logic              flag_unf,
    output logic              flag_inx
);
    logic [2:0] sticky_q;
    logic [2:0] events;
    logic [2:0] base;

    always_comb begin
        events = in_valid ? {vd.set_ovf, vd.set_unf, vd.set_inx} : 3'b000;
        base   = clr_flags ? 3'b000 : sticky_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_q  <= '0;
            out_valid <= 1'b0;
            out_word  <= '0;
            out_class <= '0;
            out_fi    <= 1'b0;
            out_fr    <= 1'b0;
        end else begin
            sticky_q  <= base | events;
            out_valid <= in_valid;
            if (in_valid) begin
                out_word  <= vd.word;
                out_class <= vd.cls;
                out_fi    <= vd.fi;
                out_fr    <= vd.fr;
            end
        end
    end

    assign flag_ovf = sticky_q[2];
    assign flag_unf = sticky_q[1];
    assign flag_inx = sticky_q[0];
endmodule

// File: rtl/fp_range_resolver.sv
module fp_range_resolver
    import fxr_pkg::*;
#(
    parameter int EXP_W    = 13,
    parameter int ADJ_DBL  = 1536,
    parameter int ADJ_SGL  = 192,
    parameter int EMAX_DBL = 2046,
    parameter int EMAX_SGL = 254
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_sign,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [51:0]             in_frac,
    input  logic                    in_single,
    input  logic                    in_zero,
    input  logic                    in_tiny,
    input  logic                    rnd_inexact,
    input  logic                    rnd_up,
    input  logic [63:0]             den_word,
    input  logic                    den_inexact,
    input  logic                    den_up,
    input  logic                    den_zero,
    input  logic [1:0]              rmode,
    input  logic                    ovf_en,
    input  logic                    unf_en,
    input  logic                    clr_flags,
    output logic                    out_valid,
    output logic [63:0]             out_word,
    output logic [4:0]              out_class,
    output logic                    out_fi,
    output logic                    out_fr,
    output logic                    flag_ovf,
    output logic                    flag_unf,
    output logic                    flag_inx
);
    kind_e    kind;
    verdict_t vd;

    fxr_detect #(
        .EXP_W(EXP_W), .EMAX_DBL(EMAX_DBL), .EMAX_SGL(EMAX_SGL)
    ) u_detect (
        .in_exp(in_exp), .in_single(in_single), .in_zero(in_zero),
        .in_tiny(in_tiny), .ovf_en(ovf_en), .unf_en(unf_en), .kind(kind)
    );

    fxr_select #(
        .EXP_W(EXP_W), .ADJ_DBL(ADJ_DBL), .ADJ_SGL(ADJ_SGL)
    ) u_select (
        .kind(kind), .in_sign(in_sign), .in_exp(in_exp), .in_frac(in_frac),
        .in_single(in_single), .rnd_inexact(rnd_inexact), .rnd_up(rnd_up),
        .den_word(den_word), .den_inexact(den_inexact), .den_up(den_up),
        .den_zero(den_zero), .rmode(rmode), .vd(vd)
    );

    fxr_status u_status (
        .clk(clk), .rst(rst), .in_valid(in_valid), .clr_flags(clr_flags),
        .vd(vd), .out_valid(out_valid), .out_word(out_word),
        .out_class(out_class), .out_fi(out_fi), .out_fr(out_fr),
        .flag_ovf(flag_ovf), .flag_unf(flag_unf), .flag_inx(flag_inx)
    );
endmodule

// File: rtl/fxr_checker.sv
module fxr_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        clr_flags,
    input logic        out_valid,
    input logic [63:0] out_word,
    input logic [4:0]  out_class,
    input logic        out_fi,
    input logic        out_fr,
    input logic        flag_ovf,
    input logic        flag_unf,
    input logic        flag_inx
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_ovf && !clr_flags) |=> flag_ovf);
    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_flags && !in_valid) |=> (!flag_ovf && !flag_unf && !flag_inx));
    // R4
    inf_marks_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_word[62:52] == 11'h7ff) |-> (out_fi && !out_fr && flag_inx && flag_ovf));
    // R11
    class_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(out_class) >= 1 && $onehot0(out_class[3:2])));
endmodule

bind fp_range_resolver fxr_checker u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .clr_flags(clr_flags),
    .out_valid(out_valid), .out_word(out_word), .out_class(out_class),
    .out_fi(out_fi), .out_fr(out_fr), .flag_ovf(flag_ovf),
    .flag_unf(flag_unf), .flag_inx(flag_inx)
);

// File: tb/fp_range_resolver_tb.sv
module fp_range_resolver_tb;

    typedef struct {
        logic [63:0] word;
        logic [4:0]  cls;
        logic        fi;
        logic        fr;
        logic [2:0]  flags;
        string       tag;
    } exp_t;

    logic clk = 0;
    logic rst = 1;
    logic in_valid = 0, in_sign = 0, in_single = 0, in_zero = 0, in_tiny = 0;
    logic signed [12:0] in_exp = '0;
    logic [51:0] in_frac = '0;
    logic rnd_inexact = 0, rnd_up = 0, den_inexact = 0, den_up = 0, den_zero = 0;
    logic [63:0] den_word = '0;
    logic [1:0] rmode = 0;
    logic ovf_en = 0, unf_en = 0, clr_flags = 0;
    logic out_valid, out_fi, out_fr, flag_ovf, flag_unf, flag_inx;
    logic [63:0] out_word;
    logic [4:0] out_class;

    int errors = 0;
    int checks = 0;
    exp_t sb[$];
    logic [2:0] mflags = 3'b000;
    bit done = 0;

    always #4 clk = ~clk;

    fp_range_resolver u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
        .in_exp(in_exp), .in_frac(in_frac), .in_single(in_single),
        .in_zero(in_zero), .in_tiny(in_tiny), .rnd_inexact(rnd_inexact),
        .rnd_up(rnd_up), .den_word(den_word), .den_inexact(den_inexact),
        .den_up(den_up), .den_zero(den_zero), .rmode(rmode),
        .ovf_en(ovf_en), .unf_en(unf_en), .clr_flags(clr_flags),
        .out_valid(out_valid), .out_word(out_word), .out_class(out_class),
        .out_fi(out_fi), .out_fr(out_fr), .flag_ovf(flag_ovf),
        .flag_unf(flag_unf), .flag_inx(flag_inx)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Drive one result and push its expected outcome.
    task automatic send(input string tag, input logic s, input int e, input logic [51:0] f,
                        input logic sg, input logic z, input logic t,
                        input logic ri, input logic ru, input logic [1:0] rm,
                        input logic oe, input logic ue,
                        input logic [63:0] dw, input logic di, input logic du, input logic dz,
                        input logic clr,
                        input logic [63:0] ew, input logic [4:0] ec,
                        input logic efi, input logic efr, input logic [2:0] set);
        exp_t x;
        @(posedge clk); #1;
        in_valid = 1; in_sign = s; in_exp = 13'(e); in_frac = f; in_single = sg;
        in_zero = z; in_tiny = t; rnd_inexact = ri; rnd_up = ru; rmode = rm;
        ovf_en = oe; unf_en = ue; den_word = dw; den_inexact = di; den_up = du;
        den_zero = dz; clr_flags = clr;
        mflags = (clr ? 3'b000 : mflags) | set;
        x.word = ew; x.cls = ec; x.fi = efi; x.fr = efr; x.flags = mflags; x.tag = tag;
        sb.push_back(x);
        @(posedge clk); #1;
        in_valid = 0; clr_flags = 0;
    endtask

    task automatic clear_now();
        @(posedge clk); #1; clr_flags = 1;
        mflags = 3'b000;
        @(posedge clk); #1; clr_flags = 0;
        check("R9 clear", {61'd0, flag_ovf, flag_unf, flag_inx}, 64'd0);
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check("R1 unexpected output", 64'd1, 64'd0);
            end else begin
                exp_t x;
                x = sb.pop_front();
                check({x.tag, " word"}, out_word, x.word);
                check({x.tag, " class R11"}, {59'd0, out_class}, {59'd0, x.cls});
                check({x.tag, " fi/fr"}, {62'd0, out_fi, out_fr}, {62'd0, x.fi, x.fr});
                check({x.tag, " flags R9"}, {61'd0, flag_ovf, flag_unf, flag_inx}, {61'd0, x.flags});
            end
        end
    end

    initial begin
        #1500000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    localparam logic [51:0] FR1 = 52'h8_0000_0000_0001;
    localparam logic [51:0] FS1 = {23'h40_0001, 29'd0};
    localparam logic [63:0] DBIG_P = {1'b0, 11'd2046, {52{1'b1}}};
    localparam logic [63:0] DBIG_N = {1'b1, 11'd2046, {52{1'b1}}};
    localparam logic [63:0] SBIG_P = {1'b0, 11'd1150, {23{1'b1}}, 29'd0};
    localparam logic [63:0] INF_P = {1'b0, 11'h7ff, 52'd0};
    localparam logic [63:0] INF_N = {1'b1, 11'h7ff, 52'd0};
    localparam logic [63:0] DEN = 64'h8000_0000_0123_4567;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check("R1 reset valid", {63'd0, out_valid}, 64'd0);
        check("R9 reset flags", {61'd0, flag_ovf, flag_unf, flag_inx}, 64'd0);

        // R11 plain double, exact
        send("R11 normal", 0, 1000, FR1, 0,0,0, 0,0, 0, 0,0, 0,0,0,0, 0,
             {1'b0, 11'd1000, FR1}, 5'b00100, 0, 0, 3'b000);
        // R8 inexact in range
        send("R8 inexact", 1, 5, FR1, 0,0,0, 1,1, 0, 0,0, 0,0,0,0, 0,
             {1'b1, 11'd5, FR1}, 5'b01000, 1, 1, 3'b001);
        // R11 zero
        send("R11 zero", 1, 0, 52'd0, 0,1,0, 0,0, 0, 0,0, 0,0,0,0, 0,
             {1'b1, 63'd0}, 5'b10010, 0, 0, 3'b000);
        // R10 single rebias
        send("R10 single", 0, 130, FS1, 1,0,0, 0,0, 0, 0,0, 0,0,0,0, 0,
             {1'b0, 11'd1026, FS1}, 5'b00100, 0, 0, 3'b000);
        clear_now();

        // R2 boundary: exponent 2046 is in range
        send("R2 edge", 0, 2046, FR1, 0,0,0, 0,0, 0, 0,0, 0,0,0,0, 0,
             {1'b0, 11'd2046, FR1}, 5'b00100, 0, 0, 3'b000);
        // R3 R4 saturating overflow, all modes and signs
        send("R3 near+", 0, 2047, FR1, 0,0,0, 0,0, 0, 0,0, 0,0,0,0, 0, INF_P, 5'b00101, 1,0, 3'b101);
        send("R3 near-", 1, 2100, FR1, 0,0,0, 0,1, 0, 0,0, 0,0,0,0, 0, INF_N, 5'b01001, 1,0, 3'b101);
        send("R3 zero+", 0, 2100, FR1, 0,0,0, 0,0, 1, 0,0, 0,0,0,0, 0, DBIG_P, 5'b00100, 1,0, 3'b101);
        send("R3 zero-", 1, 2100, FR1, 0,0,0, 0,0, 1, 0,0, 0,0,0,0, 0, DBIG_N, 5'b01000, 1,0, 3'b101);
        send("R3 pinf+", 0, 2100, FR1, 0,0,0, 0,0, 2, 0,0, 0,0,0,0, 0, INF_P, 5'b00101, 1,0, 3'b101);
        send("R3 pinf-", 1, 2100, FR1, 0,0,0, 0,0, 2, 0,0, 0,0,0,0, 0, DBIG_N, 5'b01000, 1,0, 3'b101);
        send("R3 minf+", 0, 2100, FR1, 0,0,0, 0,0, 3, 0,0, 0,0,0,0, 0, DBIG_P, 5'b00100, 1,0, 3'b101);
        send("R3 minf-", 1, 2100, FR1, 0,0,0, 0,0, 3, 0,0, 0,0,0,0, 0, INF_N, 5'b01001, 1,0, 3'b101);
        // R10 R3 single saturation to largest finite
        send("R10 single big", 0, 255, FS1, 1,0,0, 0,0, 1, 0,0, 0,0,0,0, 0, SBIG_P, 5'b00100, 1,0, 3'b101);
        clear_now();

        // R5 trapped overflow double and single; R2 flag with enable set
        send("R5 trap dbl", 1, 2100, FR1, 0,0,0, 0,1, 0, 1,0, 0,0,0,0, 0,
             {1'b1, 11'd564, FR1}, 5'b01000, 0, 1, 3'b100);
        send("R5 trap sgl", 0, 300, FS1, 1,0,0, 1,0, 0, 1,0, 0,0,0,0, 0,
             {1'b0, 11'd1004, FS1}, 5'b00100, 1, 0, 3'b101);
        clear_now();

        // R6 trapped underflow
        send("R6 trap dbl", 0, -50, FR1, 0,0,1, 0,0, 0, 0,1, 0,0,0,0, 0,
             {1'b0, 11'd1486, FR1}, 5'b00100, 0, 0, 3'b010);
        send("R6 trap sgl", 1, -20, FS1, 1,0,1, 0,0, 0, 0,1, 0,0,0,0, 0,
             {1'b1, 11'd1068, FS1}, 5'b01000, 0, 0, 3'b010);
        clear_now();

        // R7 untrapped exact: no underflow flag
        send("R7 den exact", 1, -5, FR1, 0,0,1, 1,1, 0, 0,0, DEN,0,0,0, 0,
             DEN, 5'b11000, 0, 0, 3'b000);
        // R7 R8 untrapped with loss
        send("R7 den lossy", 1, -5, FR1, 0,0,1, 0,0, 0, 0,0, DEN,1,1,0, 0,
             DEN, 5'b11000, 1, 1, 3'b011);
        // R7 denormalized to zero
        send("R7 den zero", 0, -900, FR1, 0,0,1, 0,0, 0, 0,0, 64'd0,1,0,1, 0,
             64'd0, 5'b00010, 1, 0, 3'b011);
        // R9 clear in the same cycle as an overflow: overflow survives
        send("R9 clr+event", 0, 2100, FR1, 0,0,0, 0,0, 0, 1,0, 0,0,0,0, 1,
             {1'b0, 11'd564, FR1}, 5'b00100, 0, 0, 3'b100);

        repeat (4) @(posedge clk);
        check("R1 drained", 64'(sb.size()), 64'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule